// File: doc/BRIEF.md
# Interval Measurement Statistics Engine

This block measures time intervals on one digital input against a free-running cycle counter and reduces each block of measurements to the figures a host needs for frequency and jitter tests. After a start pulse, the engine latches its mode, gate length and block length. It then waits for the first edge that opens a measurement. From that edge on, it forms one sample each time an interval completes. An interval is one of four kinds:

- the time from one rising edge to the next;
- a high pulse, measured from rise to fall;
- a low pulse, measured from fall to rise;
- the number of rising edges inside each fixed gate window.

Each sample is sent out on a raw stream. Every raw sample carries two tags. The first is the time at which the sample completed, counted from the opening edge. The second is the number of input transitions seen since that edge. Meanwhile the accumulator keeps the minimum, maximum, sum and sum of squares of the samples. When the programmed number of samples has arrived, the engine raises a one-cycle done pulse and holds every statistic until the next start. The host then divides the sum by the count to get the mean, and derives the standard deviation from the two sums. The spread between maximum and minimum is output directly as peak-to-peak jitter.

Top module: `ivstat_engine`

## Requirements
- R1: After reset, busy, done and raw_valid are low, and all statistics outputs read zero.
- R2: With mode 0, each sample is the number of clock cycles between two consecutive rising edges. The first rising edge after start only sets the reference and produces no sample.
- R3: With mode 1, each sample is the number of cycles from a rising edge to the following falling edge.
- R4: With mode 2, each sample is the number of cycles from a falling edge to the following rising edge. Edges before the first falling edge after start are ignored.
- R5: With mode 3, the first rising edge starts a run of back-to-back gates, each gate_len cycles long. Each sample is the count of rising edges in cycles 1 to gate_len of its gate, counted after the gate's opening cycle.
- R6: raw_time gives the cycles from the opening edge to the cycle that completed the sample. raw_event gives the number of input transitions from the opening edge (which counts as 0) up to and including that cycle.
- R7: The minimum and maximum are taken from the first sample of the block, not from reset or constant values.
- R8: done is high for exactly one cycle, one cycle after the raw_valid of the final sample. busy falls in the same cycle that done rises.
- R9: stat_p2p equals stat_max minus stat_min. All statistics hold their values from done until the next start.
- R10: stat_sum and stat_sumsq are exact for any block of up to MAX_N samples. The sum of squares is 2*SW+clog2(MAX_N+1) bits wide.
- R11: Once the block length has been reached, no further raw samples appear until the next start, even while the input keeps toggling.
- R12: A start pulse while a block is running discards the partial block and begins a new one with the newly presented settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Measured signal, synchronous to clk |
| start | input | 1 | One-cycle pulse that begins a block and latches the settings |
| mode | input | 2 | 0 period, 1 high pulse, 2 low pulse, 3 edge count per gate |
| gate_len | input | GW | Gate length in cycles for mode 3 |
| block_len | input | CW | Samples per block (0 is treated as 1) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse when the block completes |
| raw_valid | output | 1 | Raw sample present |
| raw_value | output | SW | Raw sample value |
| raw_time | output | TW | Cycles since the opening edge |
| raw_event | output | TW | Transitions since the opening edge |
| stat_min | output | SW | Block minimum |
| stat_max | output | SW | Block maximum |
| stat_p2p | output | SW | Maximum minus minimum |
| stat_sum | output | SW+CW | Sum of samples |
| stat_sumsq | output | 2*SW+CW | Sum of squared samples |

## Verification
A change on sig_in that is seen at clock edge k produces its raw sample in the cycle after edge k. The accumulator takes that sample at the next edge, so done and the updated statistics appear one cycle after the final raw_valid. The bench drives sig_in on falling edges and samples every output on falling edges. It records the cycle number of each raw sample and of done, and checks that they are exactly one cycle apart. Interval values and tags are checked by their order in the stream and compared against figures computed from the segment lengths the bench drove. The statistics are read again well after done to confirm they have not changed.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
    typedef enum logic [1:0] {
        MODE_PERIOD   = 2'd0,
        MODE_PW_HIGH  = 2'd1,
        MODE_PW_LOW   = 2'd2,
        MODE_EDGE_CNT = 2'd3
    } meas_mode_e;
endpackage

// File: rtl/ivs_timebase.sv
module ivs_timebase #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] now_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign now_o = cnt_q;
endmodule

// File: rtl/ivs_edge_det.sv
module ivs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
        fall_o = ~sig_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ivs_sampler.sv
module ivs_sampler
    import ivs_pkg::*;
#(
    parameter int TW = 32,
    parameter int SW = 16,
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  meas_mode_e    mode_i,
    input  logic [GW-1:0] gate_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic [TW-1:0] now_i,
    input  logic          stop_i,
    output logic          busy_o,
    output logic          smp_valid_o,
    output logic [SW-1:0] smp_val_o,
    output logic [TW-1:0] smp_time_o,
    output logic [TW-1:0] smp_event_o
);
    typedef struct packed {
        logic          busy;
        logic          seen;
        meas_mode_e    mode;
        logic [GW-1:0] gate;
        logic [GW-1:0] gcnt;
        logic [TW-1:0] t0;
        logic [TW-1:0] mark;
        logic          have_mark;
        logic [TW-1:0] ev;
        logic [SW-1:0] ecnt;
        logic          vld;
        logic [SW-1:0] val;
        logic [TW-1:0] tim;
        logic [TW-1:0] evt;
    } smp_state_t;

    smp_state_t    st_d, st_q;
    logic [TW-1:0] ev_now;
    logic [SW-1:0] span;
    logic [SW-1:0] cnt_nx;
    logic [GW-1:0] gnext;
    logic          open_edge;
    logic          emit;
    logic [SW-1:0] emit_val;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        emit      = 1'b0;
        emit_val  = '0;
        ev_now    = st_q.ev + TW'(rise_i | fall_i);
        span      = SW'(now_i - st_q.mark);
        cnt_nx    = st_q.ecnt + SW'(rise_i);
        gnext     = st_q.gcnt + 1'b1;
        open_edge = (st_q.mode == MODE_PW_LOW) ? fall_i : rise_i;

        if (start_i) begin
            st_d.busy      = 1'b1;
            st_d.seen      = 1'b0;
            st_d.mode      = mode_i;
            st_d.gate      = gate_i;
            st_d.have_mark = 1'b0;
            st_d.gcnt      = '0;
            st_d.ecnt      = '0;
            st_d.ev        = '0;
        end else if (st_q.busy && stop_i) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && !st_q.seen) begin
            if (open_edge) begin
                st_d.seen      = 1'b1;
                st_d.t0        = now_i;
                st_d.mark      = now_i;
                st_d.have_mark = 1'b1;
            end
        end else if (st_q.busy) begin
            st_d.ev = ev_now;
            case (st_q.mode)
                MODE_PERIOD: begin
                    if (rise_i) begin
                        emit      = 1'b1;
                        emit_val  = span;
                        st_d.mark = now_i;
                    end
                end
                MODE_PW_HIGH: begin
                    if (rise_i) begin
                        st_d.mark      = now_i;
                        st_d.have_mark = 1'b1;
                    end else if (fall_i && st_q.have_mark) begin
                        emit           = 1'b1;
                        emit_val       = span;
                        st_d.have_mark = 1'b0;
                    end
                end
                MODE_PW_LOW: begin
                    if (fall_i) begin
                        st_d.mark      = now_i;
                        st_d.have_mark = 1'b1;
                    end else if (rise_i && st_q.have_mark) begin
                        emit           = 1'b1;
                        emit_val       = span;
                        st_d.have_mark = 1'b0;
                    end
                end
                default: begin
                    if (gnext >= st_q.gate) begin
                        emit      = 1'b1;
                        emit_val  = cnt_nx;
                        st_d.gcnt = '0;
                        st_d.ecnt = '0;
                    end else begin
                        st_d.gcnt = gnext;
                        st_d.ecnt = cnt_nx;
                    end
                end
            endcase
            if (emit) begin
                st_d.vld = 1'b1;
                st_d.val = emit_val;
                st_d.tim = now_i - st_q.t0;
                st_d.evt = ev_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign smp_valid_o = st_q.vld;
    assign smp_val_o   = st_q.val;
    assign smp_time_o  = st_q.tim;
    assign smp_event_o = st_q.evt;
endmodule

// File: rtl/ivs_accum.sv
module ivs_accum #(
    parameter int SW   = 16,
    parameter int CW   = 11,
    parameter int SUMW = 27,
    parameter int SQW  = 43
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CW-1:0]   n_i,
    input  logic            smp_valid_i,
    input  logic [SW-1:0]   smp_val_i,
    output logic            last_o,
    output logic            done_o,
    output logic [SW-1:0]   min_o,
    output logic [SW-1:0]   max_o,
    output logic [SUMW-1:0] sum_o,
    output logic [SQW-1:0]  sumsq_o
);
    typedef struct packed {
        logic            active;
        logic [CW-1:0]   n;
        logic [CW-1:0]   cnt;
        logic [SW-1:0]   mn;
        logic [SW-1:0]   mx;
        logic [SUMW-1:0] sum;
        logic [SQW-1:0]  sq;
        logic            done;
    } acc_state_t;

    acc_state_t    ac_d, ac_q;
    logic [CW-1:0] cnt_inc;
    logic [SQW-1:0] square;

    always_comb begin
        ac_d      = ac_q;
        ac_d.done = 1'b0;
        cnt_inc   = ac_q.cnt + 1'b1;
        square    = SQW'(smp_val_i) * SQW'(smp_val_i);
        last_o    = ac_q.active && smp_valid_i && !start_i && (cnt_inc == ac_q.n);

        if (start_i) begin
            ac_d.active = 1'b1;
            ac_d.n      = (n_i == '0) ? CW'(1) : n_i;
            ac_d.cnt    = '0;
            ac_d.mn     = '0;
            ac_d.mx     = '0;
            ac_d.sum    = '0;
            ac_d.sq     = '0;
        end else if (ac_q.active && smp_valid_i) begin
            ac_d.cnt = cnt_inc;
            if (ac_q.cnt == '0) begin
                ac_d.mn = smp_val_i;
                ac_d.mx = smp_val_i;
            end else begin
                if (smp_val_i < ac_q.mn) ac_d.mn = smp_val_i;
                if (smp_val_i > ac_q.mx) ac_d.mx = smp_val_i;
            end
            ac_d.sum = ac_q.sum + SUMW'(smp_val_i);
            ac_d.sq  = ac_q.sq + square;
            if (last_o) begin
                ac_d.active = 1'b0;
                ac_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign done_o  = ac_q.done;
    assign min_o   = ac_q.mn;
    assign max_o   = ac_q.mx;
    assign sum_o   = ac_q.sum;
    assign sumsq_o = ac_q.sq;
endmodule

// File: rtl/ivstat_engine.sv
module ivstat_engine
    import ivs_pkg::*;
#(
    parameter  int TW    = 32,
    parameter  int SW    = 16,
    parameter  int GW    = 16,
    parameter  int MAX_N = 1024,
    localparam int CW    = $clog2(MAX_N + 1),
    localparam int SUMW  = SW + CW,
    localparam int SQW   = 2 * SW + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_in,
    input  logic            start,
    input  logic [1:0]      mode,
    input  logic [GW-1:0]   gate_len,
    input  logic [CW-1:0]   block_len,
    output logic            busy,
    output logic            done,
    output logic            raw_valid,
    output logic [SW-1:0]   raw_value,
    output logic [TW-1:0]   raw_time,
    output logic [TW-1:0]   raw_event,
    output logic [SW-1:0]   stat_min,
    output logic [SW-1:0]   stat_max,
    output logic [SW-1:0]   stat_p2p,
    output logic [SUMW-1:0] stat_sum,
    output logic [SQW-1:0]  stat_sumsq
);
    logic [TW-1:0] now;
    logic          rise, fall;
    logic          last;

    ivs_timebase #(.TW(TW)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now)
    );

    ivs_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    ivs_sampler #(.TW(TW), .SW(SW), .GW(GW)) u_smp (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .mode_i      (meas_mode_e'(mode)),
        .gate_i      (gate_len),
        .rise_i      (rise),
        .fall_i      (fall),
        .now_i       (now),
        .stop_i      (last),
        .busy_o      (busy),
        .smp_valid_o (raw_valid),
        .smp_val_o   (raw_value),
        .smp_time_o  (raw_time),
        .smp_event_o (raw_event)
    );

    ivs_accum #(.SW(SW), .CW(CW), .SUMW(SUMW), .SQW(SQW)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .n_i         (block_len),
        .smp_valid_i (raw_valid),
        .smp_val_i   (raw_value),
        .last_o      (last),
        .done_o      (done),
        .min_o       (stat_min),
        .max_o       (stat_max),
        .sum_o       (stat_sum),
        .sumsq_o     (stat_sumsq)
    );

    assign stat_p2p = stat_max - stat_min;
endmodule

// File: rtl/ivstat_engine_chk.sv
module ivstat_engine_chk #(
    parameter int SW   = 16,
    parameter int SUMW = 27,
    parameter int SQW  = 43
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            raw_valid,
    input logic [SW-1:0]   stat_min,
    input logic [SW-1:0]   stat_max,
    input logic [SUMW-1:0] stat_sum,
    input logic [SQW-1:0]  stat_sumsq
);
    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy has dropped by the cycle done is shown
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: extremes come from real samples, so they are ordered
    p_min_le_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> stat_min <= stat_max);

    // R9: results hold while idle
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !done) |-> $stable({stat_min, stat_max, stat_sum, stat_sumsq}));

    // R11: no raw sample unless a block was running
    p_no_extra_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> $past(busy));

    // R10: the sums never wrap below their largest term
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (stat_sum >= SUMW'(stat_max)) &&
                 (stat_sumsq >= SQW'(stat_max) * SQW'(stat_max)));
endmodule

bind ivstat_engine ivstat_engine_chk #(.SW(SW), .SUMW(SUMW), .SQW(SQW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .raw_valid  (raw_valid),
    .stat_min   (stat_min),
    .stat_max   (stat_max),
    .stat_sum   (stat_sum),
    .stat_sumsq (stat_sumsq)
);

// File: tb/ivstat_engine_tb_top.sv
module ivstat_engine_tb_top;
    localparam int TW = 32, SW = 16, GW = 16, MAX_N = 1024;
    localparam int CW = $clog2(MAX_N + 1);
    localparam int SUMW = SW + CW, SQW = 2 * SW + CW;

    logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [GW-1:0] gate_len = '0;
    logic [CW-1:0] block_len = '0;
    logic busy, done, raw_valid;
    logic [SW-1:0] raw_value, stat_min, stat_max, stat_p2p;
    logic [TW-1:0] raw_time, raw_event;
    logic [SUMW-1:0] stat_sum;
    logic [SQW-1:0] stat_sumsq;

    always #4 clk = ~clk;

    ivstat_engine dut_i (.*);

    int checks = 0, fails = 0;
    int cyc = 0, cap_n = 0, done_n = 0, done_cyc = 0;
    longint cap_val[0:63], cap_time[0:63], cap_evt[0:63];
    int cap_cyc[0:63];
    longint snap_min, snap_max, snap_sum, snap_sq;
    int hi[0:15], lo[0:15], nseg;
    longint ev_val[0:31], ev_time[0:31], ev_evt[0:31];

    always @(negedge clk) if (rst_n) begin
        cyc <= cyc + 1;
        if (raw_valid && cap_n < 64) begin
            cap_val[cap_n] <= longint'(raw_value);
            cap_time[cap_n] <= longint'(raw_time);
            cap_evt[cap_n] <= longint'(raw_event);
            cap_cyc[cap_n] <= cyc;
            cap_n <= cap_n + 1;
        end
        if (done) begin
            done_n <= done_n + 1;
            done_cyc <= cyc;
            snap_min <= longint'(stat_min);
            snap_max <= longint'(stat_max);
            snap_sum <= longint'(stat_sum);
            snap_sq <= longint'(stat_sumsq);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_segs(input int n, input int h, input int l);
        nseg = n;
        for (int i = 0; i < n; i++) begin hi[i] = h; lo[i] = l; end
    endtask

    task automatic drive_segs(input int count);
        for (int i = 0; i < count; i++) begin
            sig_in = 1'b1;
            repeat (hi[i]) @(negedge clk);
            sig_in = 1'b0;
            repeat (lo[i]) @(negedge clk);
        end
    endtask

    // Expected samples from segment lengths (first rise at time 0)
    task automatic expect_samples(input int md, input int n, input int g);
        longint r[0:16];
        r[0] = 0;
        for (int i = 0; i < nseg; i++) r[i+1] = r[i] + hi[i] + lo[i];
        for (int k = 1; k <= n; k++) begin
            case (md)
                0: begin ev_val[k-1] = hi[k-1] + lo[k-1]; ev_time[k-1] = r[k]; ev_evt[k-1] = 2*k; end
                1: begin ev_val[k-1] = hi[k-1]; ev_time[k-1] = r[k-1] + hi[k-1]; ev_evt[k-1] = 2*k - 1; end
                2: begin ev_val[k-1] = lo[k-1]; ev_time[k-1] = r[k] - hi[0]; ev_evt[k-1] = 2*k - 1; end
                default: begin
                    longint c = 0, e = 0;
                    for (int j = 0; j < nseg; j++) begin
                        if (r[j] > longint'((k-1)*g) && r[j] <= longint'(k*g)) c++;
                        if (r[j] > 0 && r[j] <= longint'(k*g)) e++;
                        if (r[j] + hi[j] <= longint'(k*g)) e++;
                    end
                    ev_val[k-1] = c; ev_time[k-1] = k*g; ev_evt[k-1] = e;
                end
            endcase
        end
    endtask

    task automatic run_block(input int md, input int n, input int g, input string rq);
        longint mn, mx, sm, sq;
        cap_n = 0; done_n = 0;
        mode = 2'(md); block_len = CW'(n); gate_len = GW'(g);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R12", "busy after start", longint'(busy), 1);
        repeat (3) @(negedge clk);
        drive_segs(nseg);
        repeat (20) @(negedge clk);
        expect_samples(md, n, g);
        chk(cap_n == n, "R11", "raw sample count", cap_n, n);
        mn = ev_val[0]; mx = ev_val[0]; sm = 0; sq = 0;
        for (int k = 0; k < n && k < cap_n; k++) begin
            chk(cap_val[k] == ev_val[k], rq, $sformatf("value %0d", k), cap_val[k], ev_val[k]);
            chk(cap_time[k] == ev_time[k], "R6", $sformatf("time %0d", k), cap_time[k], ev_time[k]);
            chk(cap_evt[k] == ev_evt[k], "R6", $sformatf("event %0d", k), cap_evt[k], ev_evt[k]);
        end
        for (int k = 0; k < n; k++) begin
            if (ev_val[k] < mn) mn = ev_val[k];
            if (ev_val[k] > mx) mx = ev_val[k];
            sm += ev_val[k]; sq += ev_val[k] * ev_val[k];
        end
        chk(done_n == 1, "R8", "done pulse cycles", done_n, 1);
        if (cap_n > 0)
            chk(done_cyc == cap_cyc[cap_n-1] + 1, "R8", "done timing", done_cyc, cap_cyc[cap_n-1] + 1);
        chk(busy == 1'b0, "R8", "busy after done", longint'(busy), 0);
        chk(longint'(stat_min) == mn, "R7", "min", longint'(stat_min), mn);
        chk(longint'(stat_max) == mx, "R7", "max", longint'(stat_max), mx);
        chk(longint'(stat_p2p) == mx - mn, "R9", "p2p", longint'(stat_p2p), mx - mn);
        chk(longint'(stat_sum) == sm, "R10", "sum", longint'(stat_sum), sm);
        chk(longint'(stat_sumsq) == sq, "R10", "sumsq", longint'(stat_sumsq), sq);
        chk(snap_min == longint'(stat_min) && snap_sum == longint'(stat_sum) &&
            snap_max == longint'(stat_max) && snap_sq == longint'(stat_sumsq),
            "R9", "hold since done", longint'(stat_sum), snap_sum);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !raw_valid, "R1", "flags after reset",
            longint'({busy, done, raw_valid}), 0);
        chk(stat_min == 0 && stat_max == 0 && stat_sum == 0 && stat_sumsq == 0,
            "R1", "stats after reset", longint'(stat_sum), 0);
    endtask

    task automatic t_period;
        nseg = 7;
        hi[0]=3; lo[0]=4; hi[1]=6; lo[1]=6; hi[2]=2; lo[2]=3; hi[3]=10; lo[3]=9;
        hi[4]=5; lo[4]=4; hi[5]=4; lo[5]=4; hi[6]=3; lo[6]=3;
        run_block(0, 5, 0, "R2");
    endtask

    task automatic t_pw_high;  run_block(1, 4, 0, "R3"); endtask
    task automatic t_pw_low;   run_block(2, 4, 0, "R4"); endtask

    task automatic t_edge_cnt;
        set_segs(10, 2, 2);
        run_block(3, 3, 10, "R5");
    endtask

    task automatic t_wide;
        nseg = 6;
        hi[0]=150; lo[0]=150; hi[1]=140; lo[1]=160; hi[2]=200; lo[2]=100;
        hi[3]=120; lo[3]=130; hi[4]=5; lo[4]=5; hi[5]=5; lo[5]=5;
        run_block(0, 4, 0, "R10");
    endtask

    task automatic t_restart;
        set_segs(8, 4, 5);
        mode = 2'd1; block_len = CW'(3);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        drive_segs(2);
        chk(busy == 1'b1, "R12", "busy mid block", longint'(busy), 1);
        set_segs(8, 3, 6);
        run_block(0, 3, 0, "R12");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_pw_high();
        t_pw_low();
        t_edge_cnt();
        t_wide();
        t_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule